// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio. It does so with a pulse-swallow structure. A small prescaler counts either 8 or 9 input clocks per turn. A 3-bit swallow counter holds the prescaler at 9 for the first few turns of each output period. A 12-bit main counter sets how many prescaler turns make up one output period. The overall ratio is therefore eight times the main count plus the swallow count. The output frequency can be set in steps of one input clock.

A 15-bit ratio is presented on `ratio_i` and captured by a one-cycle `load_i` strobe. The captured value only takes effect at the next output-period boundary, so a retune never produces a short or broken period. Ratios below the smallest one the structure can produce are raised to that minimum, and a flag reports it. Two outputs are provided. The first is a one-clock pulse that marks the end of each period. The second is a square wave at half the divided rate, meant for test observation.

Top module: `swdiv_top`

## Requirements
- R1: While `rst_i` is high, `pulse_o`, `half_o` and `clamp_o` are 0. After reset the active ratio is 56, so successive `pulse_o` pulses are 56 input clocks apart.
- R2: For a captured ratio N, successive `pulse_o` pulses are exactly N rising edges of `clk_i` apart. N = 8·M + A, where A = N[2:0] is the swallow count and M = N[14:3] is the main count. This holds for every A value 0 to 7.
- R3: `pulse_o` is high for exactly one input clock per period.
- R4: A ratio captured by `load_i` part-way through a period does not change that period. The period then in progress still lasts the old ratio, and the next period uses the new one.
- R5: A captured ratio below 56 is replaced by 56. `clamp_o` is 1 after such a load, and it is 0 after a load of a ratio of 56 or more. `clamp_o` changes only when a load occurs.
- R6: `half_o` changes level in the cycle after each `pulse_o` pulse and holds its level otherwise. It is a square wave with a period of 2·N input clocks.
- R7: The largest ratio, 32767 (all 15 bits set), produces a period of 32767 input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 15 | Requested division ratio |
| load_i | input | 1 | Capture strobe for `ratio_i`, one cycle |
| pulse_o | output | 1 | One-clock pulse on the last clock of each period |
| half_o | output | 1 | Toggles once per period (half the divided rate) |
| clamp_o | output | 1 | Last captured ratio was below the minimum |

## Verification
If the prescaler, swallow counter or main counter holds a wrong count, the error shows up as a wrong spacing between `pulse_o` pulses in the very next period. A swallow fault is off by up to 7 clocks, and a main-count fault is off by a multiple of 8. The bench sweeps every swallow value across several main counts so that both kinds of error are reached. A reload taken from the wrong register, or at the wrong time, shows up as a wrong length in the period during which a load arrives, or in the period just after it. A stuck or double toggle on the half-rate output is visible one clock after the pulse.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
   // default geometry: 3-bit swallow field, 12-bit main field
   localparam int unsigned SWDIV_AW   = 3;
   localparam int unsigned SWDIV_MW   = 12;
   // smallest ratio where the swallow count never exceeds the main count
   function automatic int unsigned swdiv_min_ratio(input int unsigned aw);
      return ((1 << aw) - 1) << aw;
   endfunction
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
   parameter int unsigned AW = 3
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic swallow_i,
   output logic tc_o
);
   localparam int unsigned P  = 1 << AW;
   localparam int unsigned CW = AW + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   always_comb last = swallow_i ? CW'(P) : CW'(P - 1);
   assign tc_o = (cnt_q == last);

   always_ff @(posedge clk_i) begin
      if (rst_i)     cnt_q <= '0;
      else if (tc_o) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= CW'(P));
endmodule

// File: rtl/swdiv_cycle.sv
module swdiv_cycle #(
   parameter int unsigned AW    = 3,
   parameter int unsigned MW    = 12,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_M = 7
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tc_i,
   input  logic [AW-1:0] a_load_i,
   input  logic [MW-1:0] m_load_i,
   output logic          swallow_o,
   output logic          end_o
);
   logic [AW-1:0] a_q;
   logic [MW-1:0] m_q;

   assign swallow_o = (a_q != '0);
   assign end_o     = tc_i && (m_q == MW'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         a_q <= AW'(RST_A);
         m_q <= MW'(RST_M);
      end else if (end_o) begin
         a_q <= a_load_i;
         m_q <= m_load_i;
      end else if (tc_i) begin
         if (swallow_o) a_q <= a_q - 1'b1;
         m_q <= m_q - 1'b1;
      end
   end

   // R2
   swallow_fit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      MW'(a_q) <= m_q);
   // R3
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      end_o |=> !end_o);
endmodule

// File: rtl/swdiv_toggle.sv
module swdiv_toggle (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ev_i,
   output logic q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= 1'b0;
      else if (ev_i) q_o <= ~q_o;
   end

   // R6
   half_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ev_i |=> (q_o != $past(q_o)));
   // R6
   half_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !ev_i |=> $stable(q_o));
endmodule

// File: rtl/swdiv_top.sv
module swdiv_top
   import swdiv_pkg::*;
#(
   parameter int unsigned AW   = SWDIV_AW,
   parameter int unsigned MW   = SWDIV_MW,
   parameter int unsigned NMIN = swdiv_min_ratio(SWDIV_AW),
   localparam int unsigned NW  = AW + MW
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [NW-1:0] ratio_i,
   input  logic          load_i,
   output logic          pulse_o,
   output logic          half_o,
   output logic          clamp_o
);
   localparam int unsigned RST_A = NMIN % (1 << AW);
   localparam int unsigned RST_M = NMIN >> AW;

   if (NMIN < swdiv_min_ratio(AW)) begin : g_bad_nmin
      $error("NMIN below the smallest ratio the swallow structure supports");
   end
   if (MW < AW) begin : g_bad_mw
      $error("main field must be at least as wide as the swallow field");
   end
   if (NMIN >= (1 << NW)) begin : g_bad_range
      $error("NMIN does not fit the ratio width");
   end

   logic [NW-1:0] n_q;
   logic          below;
   logic          swallow;
   logic          pre_tc;

   assign below = (ratio_i < NW'(NMIN));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         n_q     <= NW'(NMIN);
         clamp_o <= 1'b0;
      end else if (load_i) begin
         n_q     <= below ? NW'(NMIN) : ratio_i;
         clamp_o <= below;
      end
   end

   swdiv_prescaler #(.AW(AW)) pre_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .swallow_i(swallow),
      .tc_o     (pre_tc)
   );

   swdiv_cycle #(.AW(AW), .MW(MW), .RST_A(RST_A), .RST_M(RST_M)) cyc_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .tc_i     (pre_tc),
      .a_load_i (n_q[AW-1:0]),
      .m_load_i (n_q[NW-1:AW]),
      .swallow_o(swallow),
      .end_o    (pulse_o)
   );

   swdiv_toggle half_i (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .ev_i (pulse_o),
      .q_o  (half_o)
   );

   // R5
   min_ratio_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      n_q >= NW'(NMIN));
   // R5
   clamp_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (clamp_o == ($past(ratio_i) < NW'(NMIN))));
   // R5
   clamp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(clamp_o));
endmodule

// File: tb/swdiv_top_tb_top.sv
module swdiv_top_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic [14:0] ratio_i = '0;
   logic        load_i = 1'b0;
   logic        pulse_o, half_o, clamp_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk_i = ~clk_i;

   swdiv_top dut_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .ratio_i(ratio_i),
      .load_i (load_i),
      .pulse_o(pulse_o),
      .half_o (half_o),
      .clamp_o(clamp_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      do @(negedge clk_i); while (!pulse_o);
   endtask

   // starts on a negedge where pulse_o is high; ends on the next such negedge
   task automatic measure(input int exp, input string req);
      int   cnt = 0;
      logic h0  = half_o;
      do begin
         @(negedge clk_i);
         cnt++;
         if (cnt == 1) begin
            chk(pulse_o == 1'b0, "R3 width", int'(pulse_o), 0);
            chk(half_o == ~h0, "R6 toggle", int'(half_o), int'(~h0));
         end
      end while (!pulse_o);
      chk(cnt == exp, req, cnt, exp);
   endtask

   // loads a new ratio early in the period; the period itself keeps cur
   task automatic load_period(input int n, input int cur, input bit exp_clamp);
      int cnt = 0;
      do begin
         @(negedge clk_i);
         cnt++;
         if (cnt == 1) begin
            ratio_i = 15'(n);
            load_i  = 1'b1;
         end else if (cnt == 2) begin
            load_i = 1'b0;
            chk(clamp_o == exp_clamp, "R5 clamp flag", int'(clamp_o), int'(exp_clamp));
         end
      end while (!pulse_o);
      chk(cnt == cur, "R4 old ratio kept", cnt, cur);
   endtask

   initial begin
      int cur;
      repeat (4) @(negedge clk_i);
      chk(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
      chk(half_o == 1'b0, "R1 half in reset", int'(half_o), 0);
      chk(clamp_o == 1'b0, "R1 clamp in reset", int'(clamp_o), 0);
      rst_i = 1'b0;
      wait_pulse();
      measure(56, "R1 default period");
      cur = 56;
      // R2: every swallow value over several main counts
      for (int n = 57; n <= 104; n++) begin
         load_period(n, cur, 1'b0);
         measure(n, "R2 period");
         cur = n;
      end
      for (int k = 0; k < 8; k++) begin
         load_period(4000 + k, cur, 1'b0);
         measure(4000 + k, "R2 period large");
         cur = 4000 + k;
      end
      // R5: below-minimum ratios
      load_period(0, cur, 1'b1);
      measure(56, "R5 clamp zero");
      cur = 56;
      load_period(55, cur, 1'b1);
      measure(56, "R5 clamp 55");
      load_period(57, cur, 1'b0);
      measure(57, "R5 legal clears flag");
      cur = 57;
      // R7: all-ones ratio
      load_period(32767, cur, 1'b0);
      measure(32767, "R7 max period");
      cur = 32767;
      load_period(56, cur, 1'b0);
      measure(56, "R4 return to min");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk_i);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", 190000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule